// File: doc/BRIEF.md
# Masked Readback Verifier

This block checks an FPGA configuration readback stream, one byte at a time, against two reference files held in flash. One file is a golden copy of the expected configuration. The other is a mask that marks the bits that may legally differ. For every byte position the block ANDs the readback byte with the mask byte and compares the result with the golden byte. When they differ, it counts the error and asks for a scrub of the configuration memory straight away.

The readback source and the flash reader each present a byte with a valid strobe. The flash reader supplies the golden byte and the mask byte together. The verifier compares a position only when both sides are valid, and it holds back whichever side arrives first through its ready output. A start pulse opens a pass over `LEN` byte positions. The default length covers a 368 KiB file. When the last position has been compared, the block raises a done flag and accepts no more bytes until the next start.

Top module: `rbverify_top`

## Requirements
- R1: After reset the block is idle: rb_ready, fl_ready, scrub_req and done are 0, err_count is 0, and no byte is accepted until start has been pulsed.
- R2: A start pulse clears the byte position, err_count and done, and arms a new pass. No byte is accepted in the cycle in which start is high, because both ready outputs are 0 in that cycle.
- R3: While a pass is armed, rb_ready equals fl_valid and fl_ready equals rb_valid. A position is compared only in a cycle where rb_valid and fl_valid are both 1. A side that is valid alone is stalled, and nothing is counted for it.
- R4: A position passes when fl_gold equals fl_mask AND rb_data, taken bitwise over all 8 bits. A passing position raises no scrub request and leaves err_count unchanged.
- R5: A failing position drives scrub_req to 1 for exactly the one cycle after the compare cycle. Each failing byte gives its own pulse, so back-to-back failures give back-to-back pulses.
- R6: A failing position raises the 4-bit err_count by one. The new value is visible in the cycle after the compare.
- R7: err_count saturates at 15. Further failures keep it at 15 and still raise scrub_req.
- R8: done goes to 1 in the cycle after the LEN-th position is compared and stays 1 until the next start. While done is 1, both ready outputs are 0, valid inputs are ignored, and err_count and scrub_req do not change.
- R9: The position counter is wide enough for LEN positions. The default LEN is 376832 bytes.
- R10: A mask bit of 0 makes the matching readback bit irrelevant. With a mask of 0x00, any rb_data passes against a golden byte of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle pulse that begins a pass over LEN bytes |
| rb_valid | input | 1 | Readback byte present |
| rb_data | input | DW | Readback byte |
| rb_ready | output | 1 | Readback byte is taken this cycle if rb_valid is high |
| fl_valid | input | 1 | Golden and mask bytes present |
| fl_gold | input | DW | Golden byte from flash |
| fl_mask | input | DW | Mask byte from flash |
| fl_ready | output | 1 | Flash bytes are taken this cycle if fl_valid is high |
| scrub_req | output | 1 | One-cycle request to scrub, one per failing byte |
| err_count | output | CW | Saturating count of failing bytes in this pass |
| done | output | 1 | All LEN positions have been compared |

## Verification
Two conditions are hard to reach from the ports. The first is an error count that has reached its ceiling while scrub pulses continue. The second is the boundary where the final position is compared and further valid bytes must be refused. The bench runs the pass with a short length and sends a long train of back-to-back failing bytes. It checks each pulse and each count value in the cycle after its compare, so it passes through saturation and still sees every pulse. It then drives passing bytes until the count of positions reaches the length, and keeps both valids high with a failing pattern to show that nothing more is taken. Stalls are produced by holding one side valid while the other stays low.

// File: rtl/rbverify_pkg.sv
package rbverify_pkg;

   // Byte length of one stored reference file (368 KiB).
   localparam int unsigned RBV_DEFAULT_LEN = 376832;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } rbv_phase_e;

   function automatic int unsigned rbv_pos_width(input int unsigned len);
      return (len > 1) ? $clog2(len) : 1;
   endfunction

endpackage

// File: rtl/rbv_join.sv
module rbv_join (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic start,
   input  logic rb_valid,
   input  logic fl_valid,
   output logic rb_ready,
   output logic fl_ready,
   output logic fire
);

   logic open_w;

   assign open_w   = active & ~start;
   assign rb_ready = open_w & fl_valid;
   assign fl_ready = open_w & rb_valid;
   assign fire     = rb_valid & rb_ready;

   // R3
   fire_both_sides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (fl_valid && fl_ready && rb_ready));

   // R2
   start_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!rb_ready && !fl_ready));

endmodule

// File: rtl/rbv_compare.sv
module rbv_compare #(
   parameter int unsigned DW      = 8,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] gold,
   input  logic [DW-1:0] mask,
   output logic          mismatch
);

   logic [DW-1:0] bit_miss;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("rbv_compare: DW must be at least 1");
      end
      for (genvar b = 0; b < DW; b++) begin : g_bit
         if (MASK_EN) begin : g_masked
            assign bit_miss[b] = gold[b] ^ (mask[b] & data[b]);
         end else begin : g_plain
            assign bit_miss[b] = gold[b] ^ data[b];
         end
      end
   endgenerate

   assign mismatch = |bit_miss;

endmodule

// File: rtl/rbv_errcnt.sv
module rbv_errcnt #(
   parameter int unsigned CW       = 4,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("rbv_errcnt: CW must be at least 1");
      end
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_nx = cnt_q;
            if (inc && cnt_q != TOP) cnt_nx = cnt_q + 1'b1;
         end

         // R7
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear && cnt_q == TOP) |=> (cnt_q == TOP));
      end else begin : g_wrap
         always_comb begin
            cnt_nx = cnt_q;
            if (inc) cnt_nx = cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else            cnt_q <= cnt_nx;
   end

   assign count = cnt_q;

   // R6
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !inc) |=> $stable(cnt_q));

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));

endmodule

// File: rtl/rbv_seq.sv
module rbv_seq
   import rbverify_pkg::*;
#(
   parameter int unsigned LEN = RBV_DEFAULT_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fire,
   output logic active,
   output logic done
);

   localparam int unsigned PW = rbv_pos_width(LEN);
   localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);

   rbv_phase_e    phase_q;
   logic [PW-1:0] pos_q;
   logic          at_last;

   generate
      if (LEN < 1) begin : g_bad_len
         $error("rbv_seq: LEN must be at least 1");
      end
   endgenerate

   assign at_last = (pos_q == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pos_q   <= '0;
      end else if (start) begin
         phase_q <= PH_RUN;
         pos_q   <= '0;
      end else if (fire && phase_q == PH_RUN) begin
         if (at_last) phase_q <= PH_DONE;
         else         pos_q   <= pos_q + 1'b1;
      end
   end

   assign active = (phase_q == PH_RUN);
   assign done   = (phase_q == PH_DONE);

   // R9
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST_POS);

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R8
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && at_last && !start) |=> done);

endmodule

// File: rtl/rbverify_top.sv
module rbverify_top
   import rbverify_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned LEN      = RBV_DEFAULT_LEN,
   parameter int unsigned CW       = 4,
   parameter bit          MASK_EN  = 1'b1,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rb_valid,
   input  logic [DW-1:0] rb_data,
   output logic          rb_ready,
   input  logic          fl_valid,
   input  logic [DW-1:0] fl_gold,
   input  logic [DW-1:0] fl_mask,
   output logic          fl_ready,
   output logic          scrub_req,
   output logic [CW-1:0] err_count,
   output logic          done
);

   logic active;
   logic fire;
   logic mismatch;
   logic bad_hit;
   logic scrub_q;

   generate
      if (DW < 1 || CW < 1 || LEN < 1) begin : g_bad_param
         $error("rbverify_top: DW, CW and LEN must all be at least 1");
      end
   endgenerate

   rbv_join u_join (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .start    (start),
      .rb_valid (rb_valid),
      .fl_valid (fl_valid),
      .rb_ready (rb_ready),
      .fl_ready (fl_ready),
      .fire     (fire)
   );

   rbv_compare #(.DW(DW), .MASK_EN(MASK_EN)) u_cmp (
      .data     (rb_data),
      .gold     (fl_gold),
      .mask     (fl_mask),
      .mismatch (mismatch)
   );

   assign bad_hit = fire & mismatch;

   rbv_errcnt #(.CW(CW), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .inc   (bad_hit),
      .count (err_count)
   );

   rbv_seq #(.LEN(LEN)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .fire   (fire),
      .active (active),
      .done   (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scrub_q <= 1'b0;
      else        scrub_q <= bad_hit;
   end

   assign scrub_req = scrub_q;

   // R5
   scrub_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_req |-> (err_count != '0));

   // R3
   rb_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_ready |-> fl_valid);

   // R8
   done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rb_ready && !fl_ready));

endmodule

// File: tb/sim_rbverify_top.sv
`timescale 1ns/1ps
module sim_rbverify_top;
   localparam int DW  = 8;
   localparam int CW  = 4;
   localparam int LEN = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rb_valid = 1'b0;
   logic [DW-1:0] rb_data = '0;
   logic          rb_ready;
   logic          fl_valid = 1'b0;
   logic [DW-1:0] fl_gold = '0;
   logic [DW-1:0] fl_mask = '0;
   logic          fl_ready;
   logic          scrub_req;
   logic [CW-1:0] err_count;
   logic          done;

   always #2.5 clk = ~clk;

   rbverify_top #(.DW(DW), .LEN(LEN), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rb_valid(rb_valid), .rb_data(rb_data), .rb_ready(rb_ready),
      .fl_valid(fl_valid), .fl_gold(fl_gold), .fl_mask(fl_mask), .fl_ready(fl_ready),
      .scrub_req(scrub_req), .err_count(err_count), .done(done)
   );

   int tests = 0;
   int fails = 0;
   int exp_err = 0;
   int nbytes = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One compared byte; outcome checked in the cycle after the compare.
   task automatic beat(input logic [7:0] d, input logic [7:0] g, input logic [7:0] m);
      bit mism;
      rb_valid = 1'b1; fl_valid = 1'b1;
      rb_data = d; fl_gold = g; fl_mask = m;
      @(negedge clk);
      mism = (g != (m & d));
      nbytes++;
      if (mism && exp_err < 15) exp_err++;
      chk(scrub_req == mism, "R5 scrub pulse", scrub_req, mism);
      chk(err_count == exp_err, "R6 err count", err_count, exp_err);
      chk(done == (nbytes == LEN), "R8 done", done, (nbytes == LEN));
   endtask

   task automatic idle();
      rb_valid = 1'b0; fl_valid = 1'b0;
      @(negedge clk);
      chk(scrub_req == 1'b0, "R5 single pulse", scrub_req, 0);
   endtask

   task automatic pulse_start();
      start = 1'b1; rb_valid = 1'b1; fl_valid = 1'b1;
      rb_data = 8'hFF; fl_gold = 8'h00; fl_mask = 8'hFF;
      #1;
      chk(!rb_ready && !fl_ready, "R2 no accept in start cycle", {rb_ready, fl_ready}, 0);
      @(negedge clk);
      start = 1'b0; rb_valid = 1'b0; fl_valid = 1'b0;
      exp_err = 0; nbytes = 0;
      chk(err_count == 0, "R2 count cleared", err_count, 0);
      chk(done == 0, "R2 done cleared", done, 0);
      chk(scrub_req == 0, "R2 no compare in start cycle", scrub_req, 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rb_valid = 1'b1; fl_valid = 1'b1;
      #1;
      chk(!rb_ready && !fl_ready, "R1 idle readies", {rb_ready, fl_ready}, 0);
      @(negedge clk);
      chk(scrub_req == 0 && err_count == 0 && done == 0, "R1 reset outputs",
          {scrub_req, err_count, done}, 0);
      rb_valid = 1'b0; fl_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_pass();
      pulse_start();
      beat(8'hA5, 8'h05, 8'h0F);   // R4 masked match
      beat(8'h3C, 8'h3C, 8'hFF);   // R4 full match
      beat(8'h77, 8'h00, 8'h00);   // R10 mask 0x00 ignores data
      idle();
      chk(err_count == 0, "R4 passes leave count", err_count, 0);
   endtask

   task automatic t_mismatch();
      beat(8'hF0, 8'h10, 8'hFF);   // fail
      beat(8'hF0, 8'h10, 8'h1F);   // pass
      beat(8'h01, 8'h00, 8'h01);   // fail
      beat(8'h80, 8'h81, 8'hFF);   // fail, back to back
      idle();
   endtask

   task automatic t_stall();
      rb_valid = 1'b0; fl_valid = 1'b1;
      #1;
      chk(rb_ready == 1 && fl_ready == 0, "R3 flash only", {rb_ready, fl_ready}, 2);
      @(negedge clk);
      fl_valid = 1'b0; rb_valid = 1'b1; rb_data = 8'hEE;
      #1;
      chk(rb_ready == 0 && fl_ready == 1, "R3 readback stalled", {rb_ready, fl_ready}, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(scrub_req == 0 && err_count == exp_err, "R3 no compare while stalled",
             err_count, exp_err);
      end
      beat(8'hEE, 8'h0E, 8'hFF);   // fail once flash arrives
      idle();
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 13; i++) beat(8'h55, 8'hAA, 8'hFF);
      chk(err_count == 15, "R7 saturated", err_count, 15);
      idle();
   endtask

   task automatic t_done();
      beat(8'h12, 8'h12, 8'hFF);
      beat(8'h34, 8'h04, 8'h0F);
      beat(8'h56, 8'h00, 8'h00);
      chk(done == 1, "R8 done after last", done, 1);
      rb_data = 8'hFF; fl_gold = 8'h00; fl_mask = 8'hFF;
      #1;
      chk(!rb_ready && !fl_ready, "R8 closed after done", {rb_ready, fl_ready}, 0);
      @(negedge clk);
      chk(scrub_req == 0 && err_count == 15 && done == 1, "R8 input ignored",
          {scrub_req, err_count, done}, {1'b0, 4'd15, 1'b1});
      idle();
   endtask

   task automatic t_restart();
      pulse_start();
      beat(8'h0F, 8'h0E, 8'hFF);
      idle();
      chk(err_count == 1, "R2 fresh pass counts from zero", err_count, 1);
   endtask

   initial begin
      #1_000_000;
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_pass();
      t_mismatch();
      t_stall();
      t_saturate();
      t_done();
      t_restart();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule